// File: doc/BRIEF.md
# Per-Processor Interrupt Pending Bank

This block keeps one 32-bit interrupt pending word for each of sixteen processors. A simple word-addressed register bus gives software access to every word. The upper address bits pick the processor page, and two low address bits pick the operation: read, clear or set. Software may change only the soft-interrupt field, bits 31:17. An interrupt source path that sits outside this block drives a hardware update port. That port raises or drops the single bit that matches a priority level in the word of one processor.

Every pending word also drives the output as one flat vector, so the delivery logic for each processor can watch its own word without using the bus. The block does not handle source-to-level mapping, masking or delivery.

Top module: `cpu_pend_bank`

## Requirements
- R1: Address bits [15:12] select the processor word (0..15), and address bits [3:2] select the operation. All other address bits are ignored.
- R2: A read request at operation 0 returns the selected word on `bus_rdata` in the cycle after the request. When the previous cycle held no such read, including a read at operations 1, 2 or 3, `bus_rdata` is zero.
- R3: A write at operation 1 clears each bit in 31:17 of the selected word where `bus_wdata` is 1. Bits 16:0 are left unchanged.
- R4: A write at operation 2 sets each bit in 31:17 of the selected word where `bus_wdata` is 1. Bits 16:0 are left unchanged.
- R5: A write at operation 3 changes no word. A write never changes the word of any processor other than the selected one.
- R6: A hardware update with `hw_valid`=1 and `hw_level` L in 1..15 takes effect one cycle later in the word of processor `hw_proc`. `hw_assert`=1 sets bit L, and `hw_assert`=0 clears bit L.
- R7: A hardware update with `hw_level`=0 changes no word.
- R8: When a software write and a hardware update reach the same word in the same cycle, both take effect in that cycle. The software clear or set is applied first and the hardware bit last.
- R9: Synchronous reset clears all sixteen words to zero and clears `bus_rdata`. `bus_ready` is always 1.
- R10: `pend_out` bits [32p+31:32p] hold the registered word of processor p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request strobe, one cycle |
| bus_write | input | 1 | 1 = write request, 0 = read request |
| bus_addr | input | 16 | Byte address: [15:12] processor, [3:2] operation |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_ready | output | 1 | Always 1 |
| hw_valid | input | 1 | Hardware update strobe |
| hw_assert | input | 1 | 1 = set level bit, 0 = clear it |
| hw_level | input | 4 | Priority level, the bit number to update |
| hw_proc | input | 4 | Processor whose word is updated |
| pend_out | output | 512 | All pending words, processor p at [32p+31:32p] |

## Verification
The assertions assume that reset is held for at least one clock edge before the bus and the update port are driven. They also assume that `bus_valid` is zero during reset, so the one-cycle look-back on a read request never sees a request that predates reset. The stimulus changes every input only on the falling clock edge and pulses each strobe for exactly one cycle. It also keeps the hardware levels that matter inside 1..15, except for the single case that exercises level 0 on purpose. Same-cycle collisions are driven on purpose, so the properties that watch one path alone exclude cycles in which the other path reaches the same word.

// File: rtl/pend_bank_pkg.sv
package pend_bank_pkg;

    localparam int NUM_PROC = 16;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 16;
    localparam int PAGE_LSB = 12;
    localparam int OP_LSB   = 2;
    localparam int SOFT_LSB = 17;
    localparam int LVL_W    = 4;
    localparam int PROC_W   = $clog2(NUM_PROC);

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_SET   = 2'd2,
        OP_NONE  = 2'd3
    } bank_op_e;

    typedef struct packed {
        logic              rd;
        logic              clr;
        logic              set;
        logic [PROC_W-1:0] proc;
    } bus_cmd_t;

    typedef struct packed {
        logic              valid;
        logic              on;
        logic [LVL_W-1:0]  lvl;
        logic [PROC_W-1:0] proc;
    } hw_upd_t;

    function automatic logic [DATA_W-1:0] soft_field_mask();
        return {DATA_W{1'b1}} << SOFT_LSB;
    endfunction

endpackage

// File: rtl/pb_decode.sv
module pb_decode
    import pend_bank_pkg::*;
(
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    output bus_cmd_t          cmd
);
    bank_op_e op;

    always_comb begin
        op       = bank_op_e'(bus_addr[OP_LSB +: 2]);
        cmd.proc = bus_addr[PAGE_LSB +: PROC_W];
        cmd.rd   = bus_valid && !bus_write && (op == OP_READ);
        cmd.clr  = bus_valid &&  bus_write && (op == OP_CLEAR);
        cmd.set  = bus_valid &&  bus_write && (op == OP_SET);
    end

    // one operation at a time (R1)
    always_comb begin
        a_one_op_r1: assert ($onehot0({cmd.rd, cmd.clr, cmd.set}))
            else $error("decoder raised more than one operation");
    end

endmodule

// File: rtl/pb_slot.sv
module pb_slot
    import pend_bank_pkg::*;
#(
    parameter int SLOT_ID = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_cmd_t          cmd,
    input  logic [DATA_W-1:0] wdata,
    input  hw_upd_t           hw,
    output logic [DATA_W-1:0] pend_q
);
    localparam logic [PROC_W-1:0] MY_ID = PROC_W'(SLOT_ID);
    localparam logic [DATA_W-1:0] SOFT  = soft_field_mask();

    logic              sw_hit;
    logic              hw_hit;
    logic [DATA_W-1:0] nxt;

    assign sw_hit = (cmd.proc == MY_ID);
    assign hw_hit = hw.valid && (hw.proc == MY_ID) && (hw.lvl != '0);

    always_comb begin
        nxt = pend_q;
        if (sw_hit && cmd.clr) nxt = nxt & ~(wdata & SOFT);
        if (sw_hit && cmd.set) nxt = nxt |  (wdata & SOFT);
        if (hw_hit)            nxt[hw.lvl] = hw.on;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= nxt;
    end

    p_hw_set_r6: assert property (@(posedge clk) disable iff (rst)
        (hw_hit && hw.on) |=> pend_q[$past(hw.lvl)])
        else $error("hardware set lost");

    p_hw_clr_r6: assert property (@(posedge clk) disable iff (rst)
        (hw_hit && !hw.on) |=> !pend_q[$past(hw.lvl)])
        else $error("hardware clear lost");

    p_soft_set_r4: assert property (@(posedge clk) disable iff (rst)
        (sw_hit && cmd.set) |=> ((pend_q & $past(wdata & SOFT)) == $past(wdata & SOFT)))
        else $error("soft set lost");

    p_soft_clr_r3: assert property (@(posedge clk) disable iff (rst)
        (sw_hit && cmd.clr) |=> ((pend_q & $past(wdata & SOFT)) == '0))
        else $error("soft clear lost");

    p_low_kept_r3: assert property (@(posedge clk) disable iff (rst)
        (sw_hit && (cmd.clr || cmd.set) && !hw_hit) |=> $stable(pend_q[SOFT_LSB-1:0]))
        else $error("software write touched hardware bits");

    p_idle_kept_r5: assert property (@(posedge clk) disable iff (rst)
        (!(sw_hit && (cmd.clr || cmd.set)) && !hw_hit) |=> $stable(pend_q))
        else $error("word changed without a request");

endmodule

// File: rtl/pb_rdport.sv
module pb_rdport
    import pend_bank_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  bus_cmd_t                         cmd,
    input  logic [NUM_PROC-1:0][DATA_W-1:0]  pend_vec,
    output logic [DATA_W-1:0]                rdata
);
    always_ff @(posedge clk) begin
        if (rst)         rdata <= '0;
        else if (cmd.rd) rdata <= pend_vec[cmd.proc];
        else             rdata <= '0;
    end

    p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !cmd.rd |=> (rdata == '0))
        else $error("read data not zero after non-read cycle");

endmodule

// File: rtl/cpu_pend_bank.sv
module cpu_pend_bank
    import pend_bank_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         bus_valid,
    input  logic                         bus_write,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    output logic                         bus_ready,
    input  logic                         hw_valid,
    input  logic                         hw_assert,
    input  logic [LVL_W-1:0]             hw_level,
    input  logic [PROC_W-1:0]            hw_proc,
    output logic [NUM_PROC*DATA_W-1:0]   pend_out
);
    bus_cmd_t                        cmd;
    hw_upd_t                         hw;
    logic [NUM_PROC-1:0][DATA_W-1:0] pend_vec;

    assign bus_ready = 1'b1;
    assign hw = '{valid: hw_valid, on: hw_assert, lvl: hw_level, proc: hw_proc};

    pb_decode u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .cmd       (cmd)
    );

    for (genvar g = 0; g < NUM_PROC; g++) begin : g_slot
        pb_slot #(.SLOT_ID(g)) u_slot (
            .clk    (clk),
            .rst    (rst),
            .cmd    (cmd),
            .wdata  (bus_wdata),
            .hw     (hw),
            .pend_q (pend_vec[g])
        );
    end

    pb_rdport u_rd (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .pend_vec (pend_vec),
        .rdata    (bus_rdata)
    );

    assign pend_out = pend_vec;

endmodule

// File: tb/cpu_pend_bank_tb_top.sv
module cpu_pend_bank_tb_top;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_valid, bus_write;
    logic [15:0]   bus_addr;
    logic [31:0]   bus_wdata, bus_rdata;
    logic          bus_ready;
    logic          hw_valid, hw_assert;
    logic [3:0]    hw_level, hw_proc;
    logic [511:0]  pend_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] model [16];

    always #5 clk = ~clk;

    cpu_pend_bank dut_i (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .hw_valid(hw_valid), .hw_assert(hw_assert), .hw_level(hw_level),
        .hw_proc(hw_proc), .pend_out(pend_out)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int p = 0; p < 16; p++) check(pend_out[p*32 +: 32], model[p], tag);
    endtask

    function automatic logic [15:0] mk_addr(input int proc, input int op);
        return 16'((proc << 12) | (op << 2));
    endfunction

    task automatic bus_wr(input int proc, input int op, input logic [31:0] d);
        bus_valid = 1; bus_write = 1; bus_addr = mk_addr(proc, op); bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic [31:0] d);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        @(negedge clk);
        bus_valid = 0;
        d = bus_rdata;
    endtask

    task automatic hw_upd(input int proc, input int lvl, input bit on);
        hw_valid = 1; hw_proc = 4'(proc); hw_level = 4'(lvl); hw_assert = on;
        @(negedge clk);
        hw_valid = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check_all("R9 reset words");
        check({31'd0, bus_ready}, 32'd1, "R9 ready high");
        bus_rd(mk_addr(5, 0), d);
        check(d, 32'd0, "R2 R9 read after reset");
    endtask

    task automatic t_hw();
        logic [31:0] d;
        hw_upd(3, 7, 1);   model[3][7] = 1'b1;
        check_all("R6 set level 7 on proc 3");
        hw_upd(15, 15, 1); model[15][15] = 1'b1;
        check_all("R6 R10 set level 15 on proc 15");
        bus_rd(mk_addr(3, 0), d);
        check(d, model[3], "R2 R1 read proc 3");
        hw_upd(3, 7, 0);   model[3][7] = 1'b0;
        check_all("R6 clear level 7 on proc 3");
        hw_upd(3, 0, 1);
        check_all("R7 level 0 ignored");
    endtask

    task automatic t_soft();
        hw_upd(9, 2, 1); model[9][2] = 1'b1;
        bus_wr(9, 2, 32'hFFFF_FFFF); model[9] |= 32'hFFFE_0000;
        check_all("R4 set field proc 9");
        bus_wr(9, 1, 32'h8001_FFFF); model[9] &= ~32'h8000_0000;
        check_all("R3 clear bit 31 keeps low bits");
        bus_wr(9, 1, 32'h0F00_0000); model[9] &= ~32'h0F00_0000;
        check_all("R3 clear nibble");
    endtask

    task automatic t_offsets();
        logic [31:0] d;
        bus_wr(9, 3, 32'hFFFF_FFFF);
        check_all("R5 write op 3 ignored");
        bus_rd(mk_addr(9, 1), d); check(d, 32'd0, "R2 read op 1 zero");
        bus_rd(mk_addr(9, 2), d); check(d, 32'd0, "R2 read op 2 zero");
        bus_rd(mk_addr(9, 3), d); check(d, 32'd0, "R2 read op 3 zero");
        bus_rd(mk_addr(9, 0) | 16'h0ef3, d);
        check(d, model[9], "R1 stray address bits ignored");
        @(negedge clk);
        check(bus_rdata, 32'd0, "R2 idle cycle zero");
    endtask

    task automatic t_collide();
        bus_valid = 1; bus_write = 1; bus_addr = mk_addr(4, 2); bus_wdata = 32'h0006_0200;
        hw_valid = 1; hw_proc = 4; hw_level = 9; hw_assert = 1;
        @(negedge clk);
        bus_valid = 0; bus_write = 0; hw_valid = 0;
        model[4] |= 32'h0006_0000; model[4][9] = 1'b1;
        check_all("R8 set and hw assert same cycle");
        bus_valid = 1; bus_write = 1; bus_addr = mk_addr(4, 1); bus_wdata = 32'hFFFF_FFFF;
        hw_valid = 1; hw_proc = 4; hw_level = 9; hw_assert = 0;
        @(negedge clk);
        bus_valid = 0; bus_write = 0; hw_valid = 0;
        model[4] = 32'd0;
        check_all("R8 clear and hw deassert same cycle");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        for (int p = 0; p < 16; p++) model[p] = '0;
        rst = 1; bus_valid = 0; bus_write = 0; bus_addr = '0; bus_wdata = '0;
        hw_valid = 0; hw_assert = 0; hw_level = '0; hw_proc = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_hw();
        t_soft();
        t_offsets();
        t_collide();
        hw_upd(6, 11, 1); bus_wr(6, 2, 32'h8000_0000);
        rst = 1; @(negedge clk); rst = 0;
        for (int p = 0; p < 16; p++) model[p] = '0;
        check_all("R9 reset clears used words");
        finish_run();
    end

endmodule